// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block sits between requesters and a single-ported synchronous memory and carries out indivisible read-then-write operations used to build locks and semaphores. A request names an operation, a word address, a byte lane and a data word. The unit reads the addressed location, decides what to write back, optionally writes it, and returns the value it found before any change.

Three operations are offered. The first exchanges the whole word with the supplied data. The second reports one byte and leaves that byte at all ones. The third stores the supplied data only if the word it read was zero. A fourth encoding only reads. For as long as the memory sequence of one operation lasts, a lock output stays high so that the surrounding fabric keeps every other master off the memory. The request and response sides each use a valid/ready handshake, and the unit takes one request at a time.

Top module: `atomic_rmw_unit`

## Requirements
- R1: While reset is held and right after it, req_ready_o is 1 and rsp_valid_o, lock_o and mem_en_o are 0.
- R2: A request is taken only when req_valid_i and req_ready_o are both 1. req_ready_o stays 0 from the cycle after acceptance until the cycle after the response handshake, and requests offered while busy are not taken.
- R3: In the cycle after acceptance the unit issues a read (mem_en_o=1, mem_we_o=0) to the captured address. Read data arrives on mem_rdata_i one cycle later.
- R4: lock_o is 1 from the read cycle through the last memory cycle of the operation and 0 while the response is offered and while idle. mem_en_o is never 1 while lock_o is 0.
- R5: Opcode 2'b00 (exchange) writes the request data to the whole word (mem_be_o=4'b1111), returns the old word and sets rsp_stored_o.
- R6: Opcode 2'b01 (byte set) writes 8'hFF into byte lane k only (mem_be_o has only bit k set; lane k is data bits 8k+7 to 8k). It returns the old byte zero-extended to 32 bits and sets rsp_stored_o.
- R7: Opcode 2'b10 (store-if-zero) writes the request data to the whole word only when the word read is zero, with rsp_stored_o=1. Otherwise no write cycle occurs, rsp_stored_o=0, and the lock falls straight after the decision cycle. The old word is returned in both cases.
- R8: The response appears in the cycle after the last memory cycle. rsp_valid_o, rsp_old_o and rsp_stored_o hold steady until rsp_ready_i is 1, and the unit is idle in the following cycle.
- R9: Opcode 2'b11 (peek) reads and returns the word without any write, with rsp_stored_o=0.
- R10: The cycle after the read has no memory access. A write, when there is one, follows in the next cycle and goes to the same address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Unit idle and able to take a request |
| req_op_i | input | 2 | Operation: 00 exchange, 01 byte set, 10 store-if-zero, 11 peek |
| req_addr_i | input | AW (8) | Word address |
| req_lane_i | input | LW (2) | Byte lane for byte set |
| req_wdata_i | input | DW (32) | Data to store |
| rsp_valid_o | output | 1 | Response offered |
| rsp_ready_i | input | 1 | Response taken |
| rsp_old_o | output | DW (32) | Value found before modification |
| rsp_stored_o | output | 1 | A write was performed |
| mem_en_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | AW (8) | Memory word address |
| mem_be_o | output | DW/8 (4) | Byte write enables |
| mem_wdata_o | output | DW (32) | Memory write data |
| mem_rdata_i | input | DW (32) | Memory read data, one cycle after the read |
| lock_o | output | 1 | Memory held for this unit |

## Verification
The hardest case is a store-if-zero that follows an earlier operation on the same word. Whether the write happens, and so whether the lock stays up one more cycle, depends on memory contents that only previous traffic sets. The stimulus clears a word through the bench memory image, runs store-if-zero twice on it so that the second call sees the first one's data and skips its write, and repeats byte sets on a word already made all-ones. A busy phase with garbage requests held on the request port, and a response stalled for several cycles, show that nothing is taken twice and that the response stays steady.

// File: rtl/atomic_rmw_pkg.sv
package atomic_rmw_pkg;

  typedef enum logic [1:0] {
    OP_SWAP  = 2'b00,
    OP_BSET  = 2'b01,
    OP_CXCHG = 2'b10,
    OP_PEEK  = 2'b11
  } rmw_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_DECIDE,
    ST_WRITE,
    ST_RESP
  } rmw_state_e;

endpackage

// File: rtl/rmw_datapath.sv
module rmw_datapath
  import atomic_rmw_pkg::*;
#(
  parameter int DW = 32,
  parameter int LW = 2
) (
  input  rmw_op_e           op_i,
  input  logic [LW-1:0]     lane_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [DW-1:0]     rdata_i,
  output logic [DW-1:0]     old_o,
  output logic              write_o,
  output logic [DW-1:0]     wr_data_o,
  output logic [DW/8-1:0]   wr_be_o
);

  localparam int NB = DW / 8;

  logic [NB-1:0] lane_hot;
  logic [7:0]    lane_byte [NB];
  logic [7:0]    sel_byte;
  logic          word_zero;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lane_hot[g]  = (lane_i == LW'(g));
    assign lane_byte[g] = rdata_i[8*g +: 8];
  end

  always_comb begin
    sel_byte = 8'h00;
    for (int i = 0; i < NB; i++) begin
      if (lane_hot[i]) sel_byte = sel_byte | lane_byte[i];
    end
  end

  assign word_zero = (rdata_i == '0);

  always_comb begin
    old_o     = rdata_i;
    write_o   = 1'b0;
    wr_data_o = '0;
    wr_be_o   = '0;
    unique case (op_i)
      OP_SWAP: begin
        write_o   = 1'b1;
        wr_data_o = wdata_i;
        wr_be_o   = '1;
      end
      OP_BSET: begin
        old_o     = DW'(sel_byte);
        write_o   = 1'b1;
        wr_data_o = {NB{8'hFF}};
        wr_be_o   = lane_hot;
      end
      OP_CXCHG: begin
        write_o   = word_zero;
        wr_data_o = wdata_i;
        wr_be_o   = '1;
      end
      default: begin
        write_o   = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/rmw_fsm.sv
module rmw_fsm
  import atomic_rmw_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_fire_i,
  input  logic       write_i,
  input  logic       rsp_ready_i,
  output rmw_state_e state_o
);

  rmw_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_fire_i) state_d = ST_READ;
      ST_READ:   state_d = ST_DECIDE;
      ST_DECIDE: state_d = write_i ? ST_WRITE : ST_RESP;
      ST_WRITE:  state_d = ST_RESP;
      ST_RESP:   if (rsp_ready_i) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import atomic_rmw_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int LW = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [1:0]      req_op_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [LW-1:0]   req_lane_i,
  input  logic [DW-1:0]   req_wdata_i,
  output logic            rsp_valid_o,
  input  logic            rsp_ready_i,
  output logic [DW-1:0]   rsp_old_o,
  output logic            rsp_stored_o,
  output logic            mem_en_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW/8-1:0] mem_be_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic            lock_o
);

  localparam int NB = DW / 8;

  rmw_state_e    state;
  logic          req_fire;
  logic          cap_rsp;

  rmw_op_e       op_q;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] lane_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] old_q;
  logic          stored_q;

  logic [DW-1:0] dp_old;
  logic          dp_write;
  logic [DW-1:0] dp_wdata;
  logic [NB-1:0] dp_be;

  assign req_ready_o = (state == ST_IDLE);
  assign req_fire    = req_valid_i && req_ready_o;
  assign cap_rsp     = (state == ST_DECIDE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= OP_PEEK;
      addr_q  <= '0;
      lane_q  <= '0;
      wdata_q <= '0;
    end else if (req_fire) begin
      op_q    <= rmw_op_e'(req_op_i);
      addr_q  <= req_addr_i;
      lane_q  <= req_lane_i;
      wdata_q <= req_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      old_q    <= '0;
      stored_q <= 1'b0;
    end else if (cap_rsp) begin
      old_q    <= dp_old;
      stored_q <= dp_write;
    end
  end

  rmw_datapath #(.DW(DW), .LW(LW)) u_dp (
    .op_i      (op_q),
    .lane_i    (lane_q),
    .wdata_i   (wdata_q),
    .rdata_i   (mem_rdata_i),
    .old_o     (dp_old),
    .write_o   (dp_write),
    .wr_data_o (dp_wdata),
    .wr_be_o   (dp_be)
  );

  rmw_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_fire_i  (req_fire),
    .write_i     (dp_write),
    .rsp_ready_i (rsp_ready_i),
    .state_o     (state)
  );

  always_comb begin
    mem_en_o    = 1'b0;
    mem_we_o    = 1'b0;
    mem_be_o    = '0;
    mem_wdata_o = '0;
    if (state == ST_READ) begin
      mem_en_o = 1'b1;
      mem_be_o = '1;
    end else if (state == ST_WRITE) begin
      mem_en_o    = 1'b1;
      mem_we_o    = 1'b1;
      mem_be_o    = dp_be;
      mem_wdata_o = dp_wdata;
    end
  end

  assign mem_addr_o   = addr_q;
  assign lock_o       = (state == ST_READ) || (state == ST_DECIDE) || (state == ST_WRITE);
  assign rsp_valid_o  = (state == ST_RESP);
  assign rsp_old_o    = old_q;
  assign rsp_stored_o = stored_q;

endmodule

// File: rtl/atomic_rmw_chk.sv
module atomic_rmw_chk #(
  parameter int DW = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic            rsp_valid_o,
  input logic            rsp_ready_i,
  input logic [DW-1:0]   rsp_old_o,
  input logic            rsp_stored_o,
  input logic            mem_en_o,
  input logic            mem_we_o,
  input logic [DW/8-1:0] mem_be_o,
  input logic            lock_o
);

  localparam int NB = DW / 8;

  a_r4_access_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o |-> lock_o);

  a_r4_unlocked_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !lock_o);

  a_r2_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o || rsp_valid_o) |-> !req_ready_o);

  a_r3_read_follows_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (mem_en_o && !mem_we_o && lock_o));

  a_r10_gap_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_en_o && !mem_we_o) |=> (!mem_en_o && lock_o));

  a_r8_rsp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=>
      (rsp_valid_o && $stable(rsp_old_o) && $stable(rsp_stored_o)));

  a_r6_write_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_en_o && mem_we_o) |-> ($countones(mem_be_o) == 1 || mem_be_o == {NB{1'b1}}));

  a_r7_write_reports_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_en_o && mem_we_o) |=> (rsp_valid_o && rsp_stored_o));

endmodule

bind atomic_rmw_unit atomic_rmw_chk #(.DW(DW)) chk_i (.*);

// File: tb/atomic_rmw_unit_tb.sv
`timescale 1ns/1ps
module atomic_rmw_unit_tb_top;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [1:0]  req_op;
  logic [7:0]  req_addr;
  logic [1:0]  req_lane;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic        rsp_ready;
  logic [31:0] rsp_old;
  logic        rsp_stored;
  logic        mem_en;
  logic        mem_we;
  logic [7:0]  mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        lock;

  logic [31:0] bmem    [256];
  logic [31:0] ref_mem [256];

  int vectors;
  int miscompares;
  bit done;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  atomic_rmw_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_addr_i(req_addr), .req_lane_i(req_lane), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_old_o(rsp_old), .rsp_stored_o(rsp_stored),
    .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .lock_o(lock)
  );

  // behavioural memory with one cycle read latency
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) bmem[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else begin
        mem_rdata <= bmem[mem_addr];
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // every-clock check of lock coverage (R4)
  always @(negedge clk) begin
    if (rst_n && !done)
      check(!(mem_en && !lock), "R4", "access outside lock", {31'd0, lock}, 32'd1);
  end

  task automatic run_op(input logic [1:0] op, input logic [7:0] addr, input logic [1:0] lane,
                        input logic [31:0] wd, input int hold, input bit noise);
    logic [31:0] ow, eo, ed, mask;
    logic [3:0]  eb;
    bit          ew;
    string       tag;
    ow = ref_mem[addr];
    eo = ow; ew = 1'b0; eb = 4'h0; ed = 32'h0;
    case (op)
      2'b00: begin ew = 1'b1; eb = 4'hF; ed = wd; tag = "R5"; end
      2'b01: begin ew = 1'b1; eb = 4'b0001 << lane; ed = 32'hFF << (8*lane);
                   eo = (ow >> (8*lane)) & 32'hFF; tag = "R6"; end
      2'b10: begin if (ow == 32'h0) begin ew = 1'b1; eb = 4'hF; ed = wd; end tag = "R7"; end
      default: tag = "R9";
    endcase
    mask = {{8{eb[3]}}, {8{eb[2]}}, {8{eb[1]}}, {8{eb[0]}}};
    ref_mem[addr] = (ow & ~mask) | (ed & mask);

    @(negedge clk);
    check(req_ready == 1'b1, "R2", "ready before request", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_lane = lane; req_wdata = wd;

    @(negedge clk);   // read cycle
    if (noise) begin
      req_op = 2'b00; req_addr = addr ^ 8'h55; req_wdata = 32'hDEAD_BEEF;
    end else begin
      req_valid = 1'b0;
    end
    check(mem_en && !mem_we, "R3", "read strobe", {30'd0, mem_en, mem_we}, 32'd2);
    check(mem_addr == addr, "R3", "read address", {24'd0, mem_addr}, {24'd0, addr});
    check(lock, "R4", "lock in read", {31'd0, lock}, 32'd1);
    check(!req_ready, "R2", "ready while busy", {31'd0, req_ready}, 32'd0);

    @(negedge clk);   // decision cycle
    check(!mem_en && lock, "R10", "decision cycle quiet", {30'd0, mem_en, lock}, 32'd1);

    if (ew) begin
      @(negedge clk); // write cycle
      check(mem_en && mem_we, {tag, "/R10"}, "write strobe", {30'd0, mem_en, mem_we}, 32'd3);
      check(mem_addr == addr, "R10", "write address", {24'd0, mem_addr}, {24'd0, addr});
      check(mem_be == eb, tag, "byte enables", {28'd0, mem_be}, {28'd0, eb});
      check((mem_wdata & mask) == ed, tag, "write data", mem_wdata & mask, ed);
      check(lock, "R4", "lock in write", {31'd0, lock}, 32'd1);
    end

    @(negedge clk);   // response cycle
    req_valid = 1'b0;
    check(rsp_valid, "R8", "response valid", {31'd0, rsp_valid}, 32'd1);
    check(rsp_old == eo, tag, "old value", rsp_old, eo);
    check(rsp_stored == ew, tag, "stored flag", {31'd0, rsp_stored}, {31'd0, ew});
    check(!lock && !mem_en, "R4", "lock low in response", {30'd0, lock, mem_en}, 32'd0);
    check(!req_ready, "R2", "ready during response", {31'd0, req_ready}, 32'd0);

    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check(rsp_valid && rsp_old == eo && rsp_stored == ew, "R8", "response held",
            rsp_old, eo);
    end

    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check(!rsp_valid && req_ready, "R8", "idle after handshake",
          {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        miscompares++;
        $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
      end
    end
  end

  initial begin
    vectors = 0; miscompares = 0; done = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; rsp_ready = 1'b0;
    req_op = 2'b00; req_addr = 8'h00; req_lane = 2'b00; req_wdata = 32'h0;
    mem_rdata = 32'h0;
    for (int i = 0; i < 256; i++) begin
      bmem[i]    = (i % 8 == 0) ? 32'h0 : ((i * 32'h0101_0101) ^ 32'h5A00_0000);
      ref_mem[i] = bmem[i];
    end

    repeat (2) @(negedge clk);
    check(req_ready && !rsp_valid && !lock && !mem_en, "R1", "state in reset",
          {28'd0, req_ready, rsp_valid, lock, mem_en}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !rsp_valid && !lock && !mem_en, "R1", "state after reset",
          {28'd0, req_ready, rsp_valid, lock, mem_en}, 32'h8);

    run_op(2'b00, 8'h03, 2'b00, 32'hCAFE_0001, 0, 1'b0);  // R5 exchange
    run_op(2'b00, 8'h03, 2'b00, 32'h1234_5678, 0, 1'b0);  // R5 sees previous store
    for (int l = 0; l < 4; l++)
      run_op(2'b01, 8'h05, 2'(l), 32'h0, 0, 1'b0);        // R6 every lane
    run_op(2'b01, 8'h05, 2'b10, 32'h0, 0, 1'b0);          // R6 byte already set
    run_op(2'b01, 8'h10, 2'b01, 32'h0, 0, 1'b0);          // R6 on zero word
    run_op(2'b10, 8'h08, 2'b00, 32'h0000_00A5, 0, 1'b0);  // R7 zero: stores
    run_op(2'b10, 8'h08, 2'b00, 32'h0000_00B6, 0, 1'b0);  // R7 nonzero: skipped
    run_op(2'b10, 8'h09, 2'b00, 32'h7777_7777, 2, 1'b0);  // R7 skipped with stall
    run_op(2'b11, 8'h0A, 2'b11, 32'hFFFF_FFFF, 0, 1'b0);  // R9 peek
    run_op(2'b00, 8'h20, 2'b00, 32'h0BAD_F00D, 4, 1'b0);  // R8 stalled response
    run_op(2'b10, 8'h18, 2'b00, 32'h0000_0001, 1, 1'b1);  // R2 noise while busy
    run_op(2'b01, 8'h21, 2'b11, 32'h0, 0, 1'b1);          // R2 noise while busy
    run_op(2'b11, 8'h08, 2'b00, 32'h0, 0, 1'b0);          // R9 read back R7 result

    @(negedge clk);
    for (int i = 0; i < 256; i++)
      check(bmem[i] == ref_mem[i], "R2", "memory image", bmem[i], ref_mem[i]);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule